// File: doc/BRIEF.md
# Fixed-OR Programmable Sum-of-Products Array

This block models a programmable logic array whose AND plane is loaded at run time and whose OR plane is hard-wired. Ten primary inputs and six fed-back output values form sixteen literals. Every product term can require any literal to be true, false, or either. Each of the eight outputs owns seven product terms that are ORed together and then inverted. Each output also owns one more product term that acts as its drive enable. The pad-level three-state drive is represented by a data bit and an enable bit, not by real tristate nets.

The array is programmed one product term at a time through a synchronous write port. Each write places one 32-bit selection mask into one term slot. The outputs are combinational functions of the primary inputs and the stored masks. Outputs 0 to 5 feed their internal sum-of-products back into the AND plane, so helper terms and two-pass logic can be built. The feedback evaluation is unrolled into a fixed ladder of passes, so the logic contains no combinational loop.

Top module: `pal_array_top`

## Requirements
- R1: While reset is asserted, and after it is released, every stored mask is zero. With all masks zero, every product term evaluates to 1, so out_en is all ones and out_data is all zeros for any pin_in value.
- R2: When cfg_we is high at a rising clock edge, cfg_data is stored into term slot cfg_addr, and the outputs reflect it from that edge on. The slot number is output*8 + slot, where slots 0 to 6 are the sum terms and slot 7 is the enable term. No other slot changes.
- R3: In a mask, bit 2i set requires literal i to be 1, and bit 2i+1 set requires literal i to be 0. A term is the AND of its requirements. A mask with no bits set gives 1. A mask with both bits of one literal set gives 0.
- R4: Literals 0 to 9 are pin_in[9:0]. Literals 10 to 15 are the feedback values of outputs 0 to 5. Outputs 6 and 7 are not fed back.
- R5: While an output is enabled, out_data of that output is the complement of the OR of its seven sum terms.
- R6: out_en of an output equals the value of its enable term. While out_en is 0, out_data of that output is 0.
- R7: The feedback literal of an output carries its sum-of-products before inversion and before enable gating. Two-pass logic therefore keeps working when the source output is disabled.
- R8: For configurations without a feedback cycle, a chain of feedback dependencies through all six fed-back outputs settles to its final value. On every fed-back output, the last evaluation pass agrees with the pass before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write strobe for one product-term mask |
| cfg_addr | input | 6 | Term slot: output*8 + slot (slot 7 = enable term) |
| cfg_data | input | 32 | Selection mask; bit 2i = literal i true, bit 2i+1 = literal i false |
| pin_in | input | 10 | Primary inputs, literals 0 to 9 |
| out_data | output | 8 | Inverted sum-of-products per output, forced to 0 when disabled |
| out_en | output | 8 | Per-output drive enable from the enable term |

## Verification
The settling and feedback-sense assertions hold only if the stored configuration never contains a feedback cycle. That condition has to hold on every clock edge, including while a configuration is only partly loaded. The stimulus therefore lets a term of output j use feedback only from outputs numbered below j. Every new configuration starts from a reset, and the stimulus only adds terms after it, so each partial state is a subset of an acyclic configuration. The write-port assertions assume that cfg_addr stays inside the 64 implemented slots, which the stimulus always respects.

// File: rtl/pal_pkg.sv
package pal_pkg;
  parameter int unsigned NUM_PI    = 10;
  parameter int unsigned NUM_OUT   = 8;
  parameter int unsigned NUM_FB    = 6;
  parameter int unsigned SUM_TERMS = 7;

  localparam int unsigned NUM_LIT   = NUM_PI + NUM_FB;
  localparam int unsigned MASK_W    = 2 * NUM_LIT;
  localparam int unsigned SLOTS     = SUM_TERMS + 1;
  localparam int unsigned EN_SLOT   = SUM_TERMS;
  localparam int unsigned NUM_TERMS = NUM_OUT * SLOTS;
  localparam int unsigned ADDR_W    = $clog2(NUM_TERMS);
  // enough passes for a chain through every fed-back output plus one confirming pass
  localparam int unsigned NUM_PASS  = NUM_FB + 2;

  typedef logic [MASK_W-1:0] mask_t;
endpackage

// File: rtl/pal_rst_sync.sv
module pal_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/pal_cfg_store.sv
module pal_cfg_store import pal_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  mask_t             wdata,
  output mask_t             masks [NUM_TERMS]
);
  logic [NUM_TERMS-1:0]        wr_en;
  logic [NUM_TERMS*MASK_W-1:0] flat;

  genvar t;
  generate
    for (t = 0; t < NUM_TERMS; t++) begin : g_slot
      mask_t slot_q;
      mask_t slot_d;

      assign wr_en[t] = we && (addr == ADDR_W'(t));

      always_comb begin
        slot_d = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot_q <= '0;
        end else if (wr_en[t]) begin
          slot_q <= slot_d;
        end
      end

      assign masks[t] = slot_q;
      assign flat[t*MASK_W +: MASK_W] = slot_q;

      // R2: a strobed write lands in exactly the addressed slot
      p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(t)) |=> (slot_q == $past(wdata)));
    end
  endgenerate

  // R2: without a strobe the whole configuration keeps its value
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(flat));

  // R1: the first cycle out of reset sees an empty configuration
  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (flat == '0));
endmodule

// File: rtl/pal_term.sv
module pal_term import pal_pkg::*; (
  input  mask_t              mask,
  input  logic [NUM_LIT-1:0] lit,
  output logic               hit
);
  logic [NUM_LIT-1:0] want_hi;
  logic [NUM_LIT-1:0] want_lo;

  genvar i;
  generate
    for (i = 0; i < NUM_LIT; i++) begin : g_lit
      assign want_hi[i] = mask[2*i];
      assign want_lo[i] = mask[2*i+1];
    end
  endgenerate

  // a term fails if any required-true literal is 0 or any required-false literal is 1
  assign hit = ~|(want_hi & ~lit) & ~|(want_lo & lit);
endmodule

// File: rtl/pal_pass.sv
module pal_pass import pal_pkg::*; #(
  parameter int unsigned N_EVAL = NUM_OUT
) (
  input  mask_t             masks [N_EVAL*SUM_TERMS],
  input  logic [NUM_PI-1:0] pin_in,
  input  logic [NUM_FB-1:0] fb_in,
  output logic [N_EVAL-1:0] sop
);
  logic [NUM_LIT-1:0] lit;
  assign lit = {fb_in, pin_in};

  genvar o, k;
  generate
    for (o = 0; o < N_EVAL; o++) begin : g_out
      logic [SUM_TERMS-1:0] hits;
      for (k = 0; k < SUM_TERMS; k++) begin : g_term
        pal_term u_term (
          .mask (masks[o*SUM_TERMS+k]),
          .lit  (lit),
          .hit  (hits[k])
        );
      end
      assign sop[o] = |hits;
    end
  endgenerate
endmodule

// File: rtl/pal_array_top.sv
module pal_array_top import pal_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [MASK_W-1:0] cfg_data,
  input  logic [NUM_PI-1:0] pin_in,
  output logic [NUM_OUT-1:0] out_data,
  output logic [NUM_OUT-1:0] out_en
);
  logic rst_sync_n;

  pal_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  mask_t masks [NUM_TERMS];

  pal_cfg_store u_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_data),
    .masks (masks)
  );

  // split the slot map into the fixed OR groups and the enable terms
  mask_t sum_masks [NUM_OUT*SUM_TERMS];
  mask_t en_masks  [NUM_OUT];

  genvar o, k, p;
  generate
    for (o = 0; o < NUM_OUT; o++) begin : g_split
      for (k = 0; k < SUM_TERMS; k++) begin : g_sum
        assign sum_masks[o*SUM_TERMS+k] = masks[o*SLOTS+k];
      end
      assign en_masks[o] = masks[o*SLOTS+EN_SLOT];
    end
  endgenerate

  // settling ladder: each pass feeds the previous pass's fed-back sums
  logic [NUM_FB-1:0] fb_p [NUM_PASS-1];

  generate
    for (p = 0; p < NUM_PASS-1; p++) begin : g_pass
      if (p == 0) begin : g_first
        pal_pass #(.N_EVAL(NUM_FB)) u_pass (
          .masks  (sum_masks[0:NUM_FB*SUM_TERMS-1]),
          .pin_in (pin_in),
          .fb_in  ({NUM_FB{1'b0}}),
          .sop    (fb_p[p])
        );
      end else begin : g_next
        pal_pass #(.N_EVAL(NUM_FB)) u_pass (
          .masks  (sum_masks[0:NUM_FB*SUM_TERMS-1]),
          .pin_in (pin_in),
          .fb_in  (fb_p[p-1]),
          .sop    (fb_p[p])
        );
      end
    end
  endgenerate

  logic [NUM_FB-1:0]  fb_fin;
  logic [NUM_OUT-1:0] sop_fin;
  logic [NUM_LIT-1:0] lit_fin;
  logic [NUM_OUT-1:0] en_hit;

  assign fb_fin  = fb_p[NUM_PASS-2];
  assign lit_fin = {fb_fin, pin_in};

  pal_pass #(.N_EVAL(NUM_OUT)) u_last (
    .masks  (sum_masks),
    .pin_in (pin_in),
    .fb_in  (fb_fin),
    .sop    (sop_fin)
  );

  generate
    for (o = 0; o < NUM_OUT; o++) begin : g_en
      pal_term u_en (
        .mask (en_masks[o]),
        .lit  (lit_fin),
        .hit  (en_hit[o])
      );
    end
  endgenerate

  assign out_en   = en_hit;
  assign out_data = en_hit & ~sop_fin;

  // R8: with an acyclic configuration the last two ladder passes agree
  p_settled_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fb_p[NUM_PASS-2] == fb_p[NUM_PASS-3]);

  generate
    for (o = 0; o < NUM_FB; o++) begin : g_fbchk
      // R7: an enabled fed-back output shows the complement of the value it feeds back
      p_fb_sense_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
        out_en[o] |-> (out_data[o] == !fb_fin[o]));
    end
  endgenerate
endmodule

// File: tb/sim_pal_array_top.sv
`timescale 1ns/1ps
module sim_pal_array_top;
  import pal_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we;
  logic [ADDR_W-1:0] cfg_addr;
  logic [MASK_W-1:0] cfg_data;
  logic [NUM_PI-1:0] pin_in;
  logic [NUM_OUT-1:0] out_data;
  logic [NUM_OUT-1:0] out_en;

  always #2 clk = ~clk;

  pal_array_top u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_data (cfg_data),
    .pin_in   (pin_in),
    .out_data (out_data),
    .out_en   (out_en)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [MASK_W-1:0]  bm [NUM_TERMS];
  logic [NUM_OUT-1:0] q_d [$];
  logic [NUM_OUT-1:0] q_e [$];
  string              q_t [$];

  localparam logic [MASK_W-1:0] KILL = 3;

  function automatic logic [MASK_W-1:0] lhi(input int i);
    return MASK_W'(1) << (2*i);
  endfunction

  function automatic logic [MASK_W-1:0] llo(input int i);
    return MASK_W'(1) << (2*i+1);
  endfunction

  function automatic logic term_val(input logic [MASK_W-1:0] m, input logic [NUM_LIT-1:0] lit);
    for (int i = 0; i < NUM_LIT; i++) begin
      if (m[2*i] && !lit[i]) return 1'b0;
      if (m[2*i+1] && lit[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  // outputs evaluated in index order; the stimulus only feeds back lower-numbered outputs
  function automatic void model(input logic [NUM_PI-1:0] pi,
                                output logic [NUM_OUT-1:0] d,
                                output logic [NUM_OUT-1:0] e);
    logic [NUM_OUT-1:0] s;
    logic [NUM_LIT-1:0] lit;
    s = '0;
    for (int o = 0; o < NUM_OUT; o++) begin
      lit = {s[NUM_FB-1:0], pi};
      for (int k = 0; k < SUM_TERMS; k++)
        if (term_val(bm[o*SLOTS+k], lit)) s[o] = 1'b1;
    end
    lit = {s[NUM_FB-1:0], pi};
    for (int o = 0; o < NUM_OUT; o++) begin
      e[o] = term_val(bm[o*SLOTS+EN_SLOT], lit);
      d[o] = e[o] & ~s[o];
    end
  endfunction

  task automatic chk(input logic [NUM_PI-1:0] pi, input string tag);
    logic [NUM_OUT-1:0] d, e;
    @(negedge clk);
    pin_in = pi;
    model(pi, d, e);
    q_d.push_back(d);
    q_e.push_back(e);
    q_t.push_back(tag);
  endtask

  task automatic wr(input int addr, input logic [MASK_W-1:0] data);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_addr = ADDR_W'(addr);
    cfg_data = data;
    bm[addr] = data;
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  // slot 0 and 1 programmed, remaining sum slots forced to 0
  task automatic set_out(input int o, input logic [MASK_W-1:0] m0, input logic [MASK_W-1:0] m1);
    wr(o*SLOTS+0, m0);
    wr(o*SLOTS+1, m1);
    for (int k = 2; k < SUM_TERMS; k++) wr(o*SLOTS+k, KILL);
  endtask

  task automatic drain;
    while (q_d.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  task automatic do_reset;
    drain();
    @(negedge clk);
    rst_n = 1'b0;
    for (int t = 0; t < NUM_TERMS; t++) bm[t] = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  // monitor: pops one expectation per cycle, after the edge
  initial begin
    logic [NUM_OUT-1:0] ed, ee;
    string t;
    forever begin
      @(posedge clk);
      #1;
      if (q_d.size() > 0) begin
        ed = q_d.pop_front();
        ee = q_e.pop_front();
        t  = q_t.pop_front();
        n_chk++;
        if (out_data !== ed || out_en !== ee) begin
          n_bad++;
          $display("FAIL %s: data=%h en=%h expected data=%h en=%h", t, out_data, out_en, ed, ee);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    cfg_we   = 1'b0;
    cfg_addr = '0;
    cfg_data = '0;
    pin_in   = '0;
    for (int t = 0; t < NUM_TERMS; t++) bm[t] = '0;
    #20 rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: empty configuration
    chk(10'h000, "R1 reset state");
    chk(10'h3FF, "R1 reset state");
    chk(10'h155, "R1 reset state");

    // R3: empty term, AND of literals, contradictory term
    for (int k = 1; k < SUM_TERMS; k++) wr(k, KILL);
    chk(10'h000, "R3 empty term is one");
    wr(0, lhi(0) | lhi(1));
    for (int v = 0; v < 4; v++) chk(NUM_PI'(v), "R3 and of true literals");
    wr(0, lhi(3) | llo(3));
    chk(10'h008, "R3 both polarities give zero");

    // R5: inverted XOR from two sum terms on output 0 (R2 slot addressing)
    set_out(0, lhi(0) | llo(1), llo(0) | lhi(1));
    for (int v = 0; v < 4; v++) chk(NUM_PI'(v), "R5 inverted sum, R2 slot map");

    // R6: output 1 enabled by pin 9 (slot 15), sums all zero
    set_out(1, KILL, KILL);
    wr(1*SLOTS+EN_SLOT, lhi(9));
    chk(10'h000, "R6 enable low forces data 0");
    chk(10'h200, "R6 enable high passes data");

    // R7/R4: output 2 = inverted 3-input parity via feedback literal 10
    set_out(2, lhi(10) | llo(2), llo(10) | lhi(2));
    for (int v = 0; v < 8; v++) chk(NUM_PI'(v), "R7 two-pass parity, R4 literal 10");
    wr(0*SLOTS+EN_SLOT, KILL);
    for (int v = 0; v < 8; v++) chk(NUM_PI'(v), "R7 feedback with source disabled");

    // R8: chain through all six fed-back outputs, then outputs 6 and 7
    do_reset();
    chk(10'h2A5, "R1 reset clears configuration");
    set_out(0, lhi(0), KILL);
    for (int o = 1; o < NUM_FB; o++) set_out(o, lhi(NUM_PI+o-1) | lhi(o), KILL);
    set_out(6, lhi(NUM_PI+5) | lhi(6), KILL);
    set_out(7, llo(NUM_PI+2), KILL);
    chk(10'h3FF, "R8 full chain");
    chk(10'h3F7, "R8 chain broken at 3");
    chk(10'h07F, "R8 chain, R4 literal 15");
    chk(10'h03F, "R8 chain without pin 6");
    chk(10'h000, "R8 chain all low");
    chk(10'h1FE, "R8 chain broken at 0");

    drain();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule